// File: doc/BRIEF.md
# Block Register Transfer Sequencer

This block drives a block move between a 16-entry register bank and consecutive words of memory. A command carries a 16-bit selection mask, a 32-bit base address, a direction bit, a two-bit addressing mode and a writeback flag. The sequencer then issues one word beat for each selected register on a request/ready memory port. Each beat carries the byte address, the write enable and the index of the register that the beat belongs to. The register bank and the memory are outside the block.

Four addressing modes are supported: increment or decrement, each with the step taken before or after the access. The mode sets the first address and the updated base. Beats always climb through memory in steps of one word, and registers are always visited from the lowest selected index upward. When the sequence ends, the block gives one `done` pulse and presents the new base. A writeback strobe asks the owner of the base register to store that value. A command runs to completion once accepted. `busy` marks that period so that surrounding logic can hold off interrupts.

The controller is a four-state machine. IDLE waits for `start`; the transition IDLE->SETUP captures the command. SETUP computes the first address and the final base. SETUP->XFER is taken for a non-empty mask, and SETUP->DONE for an empty one. XFER issues beats and moves XFER->DONE when the last selected register is accepted. DONE pulses `done` and always returns DONE->IDLE.

Top module: `blk_xfer_seq`

## Requirements
- R1: While and after reset, with no command given, `busy`, `mem_req`, `done` and `base_wb` are all low.
- R2: Mode code 0 (increment, step after) with N selected registers and base B: beats at B, B+4, ..., B+4N-4; the final base is B+4N.
- R3: Mode code 1 (increment, step before): beats at B+4 through B+4N; the final base is B+4N.
- R4: Mode code 2 (decrement, step after): beats at B-4N+4 through B; the final base is B-4N.
- R5: Mode code 3 (decrement, step before): beats at B-4N through B-4; the final base is B-4N.
- R6: Exactly one beat is issued for each set mask bit. Beats go in ascending register index, with bit i of the mask selecting register i, and the lowest index takes the lowest address.
- R7: `mem_we` is 1 on every beat of a store (`cmd_load`=0) and 0 on every beat of a load. A beat keeps `mem_req`, `mem_addr`, `reg_idx` and `mem_we` unchanged until `mem_ready` is high.
- R8: `base_wb` pulses together with `done` only when the writeback flag was set and N>0. `base_out` carries the final base in the `done` cycle.
- R9: An empty mask produces no beats. `done` comes two cycles after `start` is sampled, `base_wb` stays low and `base_out` equals the base.
- R10: With `mem_ready` held high, `busy` lasts exactly N+2 cycles. `done` is high for one cycle, in the last of them.
- R11: `start` has no effect while `busy` is high, including in the `done` cycle. No extra beats follow, and `busy` is low in the cycle after `done`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Command strobe, sampled in IDLE |
| cmd_mask | input | 16 | Register selection, bit i selects register i |
| cmd_base | input | 32 | Base byte address |
| cmd_load | input | 1 | 1 = load from memory, 0 = store to memory |
| cmd_mode | input | 2 | 0 inc-after, 1 inc-before, 2 dec-after, 3 dec-before |
| cmd_wb | input | 1 | Request base writeback |
| busy | output | 1 | Command in progress |
| mem_req | output | 1 | Beat request |
| mem_we | output | 1 | Beat is a write to memory |
| mem_addr | output | 32 | Beat byte address |
| mem_ready | input | 1 | Memory accepts the current beat |
| reg_idx | output | 4 | Register index of the current beat |
| done | output | 1 | One-cycle completion pulse |
| base_out | output | 32 | Final base value, valid with done |
| base_wb | output | 1 | Strobe to write base_out into the base register |

## Verification
Two events can land in the same cycle: a fresh `start` and the `done` pulse of the command still running. The bench raises `start` once in the middle of a transfer and again exactly in the `done` cycle. It then checks that the scoreboard receives no beat it did not expect and that `busy` is low in the next cycle. A second overlap is the final ready arriving during a stall pattern. The bench judges that case by the `done` timing and by the queue being empty when `done` appears.

// File: rtl/blk_xfer_pkg.sv
package blk_xfer_pkg;

    typedef enum logic [1:0] {
        AM_INC_AFTER  = 2'd0,
        AM_INC_BEFORE = 2'd1,
        AM_DEC_AFTER  = 2'd2,
        AM_DEC_BEFORE = 2'd3
    } addr_mode_e;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_SETUP = 2'd1,
        S_XFER  = 2'd2,
        S_DONE  = 2'd3
    } seq_state_e;

endpackage

// File: rtl/blk_bit_count.sv
module blk_bit_count #(
    parameter int W   = 16,
    parameter int CW  = $clog2(W + 1)
) (
    input  logic [W-1:0]  vec,
    output logic [CW-1:0] count
);
    always_comb begin
        count = '0;
        for (int i = 0; i < W; i++) begin
            count = count + CW'(vec[i]);
        end
    end
endmodule

// File: rtl/blk_low_pick.sv
module blk_low_pick #(
    parameter int W  = 16,
    parameter int IW = $clog2(W)
) (
    input  logic [W-1:0]  vec,
    output logic [IW-1:0] idx
);
    // Scan from the top so the lowest set bit is written last.
    always_comb begin
        idx = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (vec[i]) begin
                idx = IW'(i);
            end
        end
    end
endmodule

// File: rtl/blk_addr_calc.sv
module blk_addr_calc
    import blk_xfer_pkg::*;
#(
    parameter int AW         = 32,
    parameter int CW         = 5,
    parameter int WORD_BYTES = 4
) (
    input  logic [AW-1:0] base,
    input  logic [CW-1:0] count,
    input  addr_mode_e    mode,
    output logic [AW-1:0] first_addr,
    output logic [AW-1:0] final_base
);
    localparam logic [AW-1:0] STEP = AW'(WORD_BYTES);

    logic [AW-1:0] span;
    logic [AW-1:0] up_base;
    logic [AW-1:0] dn_base;

    assign span    = AW'(count) * STEP;
    assign up_base = base + span;
    assign dn_base = base - span;

    always_comb begin
        unique case (mode)
            AM_INC_AFTER: begin
                first_addr = base;
                final_base = up_base;
            end
            AM_INC_BEFORE: begin
                first_addr = base + STEP;
                final_base = up_base;
            end
            AM_DEC_AFTER: begin
                first_addr = dn_base + STEP;
                final_base = dn_base;
            end
            AM_DEC_BEFORE: begin
                first_addr = dn_base;
                final_base = dn_base;
            end
            default: begin
                first_addr = base;
                final_base = base;
            end
        endcase
    end
endmodule

// File: rtl/blk_xfer_seq.sv
module blk_xfer_seq
    import blk_xfer_pkg::*;
#(
    parameter int NREG       = 16,
    parameter int AW         = 32,
    parameter int WORD_BYTES = 4,
    localparam int IW        = $clog2(NREG),
    localparam int CW        = $clog2(NREG + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [NREG-1:0] cmd_mask,
    input  logic [AW-1:0]   cmd_base,
    input  logic            cmd_load,
    input  logic [1:0]      cmd_mode,
    input  logic            cmd_wb,
    output logic            busy,
    output logic            mem_req,
    output logic            mem_we,
    output logic [AW-1:0]   mem_addr,
    input  logic            mem_ready,
    output logic [IW-1:0]   reg_idx,
    output logic            done,
    output logic [AW-1:0]   base_out,
    output logic            base_wb
);
    localparam logic [AW-1:0] STEP = AW'(WORD_BYTES);

    seq_state_e    st_q, st_d;
    logic [NREG-1:0] mask_q;
    logic [AW-1:0] base_q;
    logic          load_q;
    addr_mode_e    mode_q;
    logic          wb_q;
    logic          nz_q;
    logic [AW-1:0] addr_q;
    logic [AW-1:0] final_q;

    logic [CW-1:0]   sel_cnt;
    logic [IW-1:0]   low_idx;
    logic [AW-1:0]   first_addr;
    logic [AW-1:0]   final_base;
    logic [NREG-1:0] mask_rest;
    logic            beat_ok;

    blk_bit_count #(.W(NREG), .CW(CW)) u_count (
        .vec   (mask_q),
        .count (sel_cnt)
    );

    blk_low_pick #(.W(NREG), .IW(IW)) u_pick (
        .vec (mask_q),
        .idx (low_idx)
    );

    blk_addr_calc #(.AW(AW), .CW(CW), .WORD_BYTES(WORD_BYTES)) u_calc (
        .base       (base_q),
        .count      (sel_cnt),
        .mode       (mode_q),
        .first_addr (first_addr),
        .final_base (final_base)
    );

    assign mask_rest = mask_q & (mask_q - NREG'(1));
    assign beat_ok   = (st_q == S_XFER) && mem_ready;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= S_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    // Next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            S_IDLE:  if (start) st_d = S_SETUP;
            S_SETUP: st_d = (sel_cnt == '0) ? S_DONE : S_XFER;
            S_XFER:  if (mem_ready && (mask_rest == '0)) st_d = S_DONE;
            S_DONE:  st_d = S_IDLE;
            default: st_d = S_IDLE;
        endcase
    end

    // Command and walk registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q  <= '0;
            base_q  <= '0;
            load_q  <= 1'b0;
            mode_q  <= AM_INC_AFTER;
            wb_q    <= 1'b0;
            nz_q    <= 1'b0;
            addr_q  <= '0;
            final_q <= '0;
        end else begin
            if (st_q == S_IDLE && start) begin
                mask_q <= cmd_mask;
                base_q <= cmd_base;
                load_q <= cmd_load;
                mode_q <= addr_mode_e'(cmd_mode);
                wb_q   <= cmd_wb;
            end
            if (st_q == S_SETUP) begin
                addr_q  <= first_addr;
                final_q <= final_base;
                nz_q    <= (sel_cnt != '0);
            end
            if (beat_ok) begin
                mask_q <= mask_rest;
                addr_q <= addr_q + STEP;
            end
        end
    end

    // Outputs
    always_comb begin
        busy     = (st_q != S_IDLE);
        mem_req  = (st_q == S_XFER);
        mem_we   = (st_q == S_XFER) && !load_q;
        mem_addr = addr_q;
        reg_idx  = low_idx;
        done     = (st_q == S_DONE);
        base_out = final_q;
        base_wb  = (st_q == S_DONE) && wb_q && nz_q;
    end

endmodule

// File: rtl/blk_xfer_seq_chk.sv
module blk_xfer_seq_chk #(
    parameter int AW = 32,
    parameter int IW = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          busy,
    input logic          mem_req,
    input logic          mem_we,
    input logic          mem_ready,
    input logic [AW-1:0] mem_addr,
    input logic [IW-1:0] reg_idx,
    input logic          done,
    input logic          base_wb
);
    p_hold_beat_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr)
                                     && $stable(reg_idx) && $stable(mem_we)));

    p_addr_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ready) |=> (!mem_req || mem_addr == $past(mem_addr) + AW'(4)));

    p_idx_rising_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ready) |=> (!mem_req || reg_idx > $past(reg_idx)));

    p_done_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));

    p_wb_with_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
        base_wb |-> done);

    p_req_in_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req || done) |-> busy);

    p_no_req_on_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !mem_req);
endmodule

bind blk_xfer_seq blk_xfer_seq_chk #(.AW(AW), .IW(IW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_ready (mem_ready),
    .mem_addr  (mem_addr),
    .reg_idx   (reg_idx),
    .done      (done),
    .base_wb   (base_wb)
);

// File: tb/blk_xfer_seq_bench.sv
`timescale 1ns/1ps
module blk_xfer_seq_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [15:0] cmd_mask = '0;
    logic [31:0] cmd_base = '0;
    logic        cmd_load = 1'b0;
    logic [1:0]  cmd_mode = '0;
    logic        cmd_wb = 1'b0;
    logic        busy, mem_req, mem_we, done, base_wb;
    logic [31:0] mem_addr, base_out;
    logic        mem_ready = 1'b1;
    logic [3:0]  reg_idx;

    int tests = 0;
    int fails = 0;
    logic        stall_en = 1'b0;
    logic [7:0]  lfsr = 8'hA5;
    logic [36:0] exp_q[$];

    always #2.5 clk = ~clk;

    blk_xfer_seq u_blk_xfer_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .cmd_mask(cmd_mask),
        .cmd_base(cmd_base), .cmd_load(cmd_load), .cmd_mode(cmd_mode),
        .cmd_wb(cmd_wb), .busy(busy), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_ready(mem_ready), .reg_idx(reg_idx),
        .done(done), .base_out(base_out), .base_wb(base_wb)
    );

    // Ready pattern changes right after each rising edge
    always @(posedge clk) begin
        lfsr      <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        mem_ready <= stall_en ? lfsr[0] : 1'b1;
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Monitor: compares accepted beats against the scoreboard; checks stall hold
    logic        was_stall = 1'b0;
    logic [36:0] stall_val = '0;
    always @(negedge clk) begin
        if (rst_n && mem_req) begin
            if (was_stall)
                check({mem_addr, reg_idx, mem_we} == stall_val, "R7", "held beat",
                      64'({mem_addr, reg_idx, mem_we}), 64'(stall_val));
            if (mem_ready) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R11", "unexpected beat", 64'({mem_addr, reg_idx, mem_we}), 64'd0);
                end else begin
                    automatic logic [36:0] e = exp_q.pop_front();
                    check(mem_addr == e[36:5], "R2", "beat address", 64'(mem_addr), 64'(e[36:5]));
                    check(reg_idx == e[4:1], "R6", "beat register", 64'(reg_idx), 64'(e[4:1]));
                    check(mem_we == e[0], "R7", "beat direction", 64'(mem_we), 64'(e[0]));
                end
                was_stall <= 1'b0;
            end else begin
                was_stall <= 1'b1;
                stall_val <= {mem_addr, reg_idx, mem_we};
            end
        end else begin
            was_stall <= 1'b0;
        end
    end

    // Driver: computes expected beats and final base, then runs the command
    task automatic run_cmd(input logic [15:0] mask, input logic [31:0] base,
                           input bit load, input logic [1:0] mode, input bit wb,
                           input bit poke, input string req);
        int n = 0;
        logic [31:0] first, fin, span;
        int cyc = 0;
        for (int i = 0; i < 16; i++) if (mask[i]) n++;
        span = 32'(n) * 32'd4;
        case (mode)
            2'd0: begin first = base;             fin = base + span; end
            2'd1: begin first = base + 32'd4;     fin = base + span; end
            2'd2: begin first = base - span + 32'd4; fin = base - span; end
            default: begin first = base - span;   fin = base - span; end
        endcase
        begin
            int k = 0;
            for (int i = 0; i < 16; i++) begin
                if (mask[i]) begin
                    exp_q.push_back({first + 32'(k) * 32'd4, 4'(i), ~load});
                    k++;
                end
            end
        end
        @(negedge clk);
        cmd_mask = mask; cmd_base = base; cmd_load = load; cmd_mode = mode; cmd_wb = wb;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cmd_mask = 16'hFFFF; cmd_base = 32'hDEAD0000; cmd_mode = ~mode;
        forever begin
            if (busy) cyc++;
            if (done) break;
            start = poke && (cyc == 2);
            @(negedge clk);
        end
        check(exp_q.size() == 0, "R6", "beats outstanding at done", 64'(exp_q.size()), 64'd0);
        check(base_wb == (wb && n > 0), "R8", "writeback strobe", 64'(base_wb), 64'(wb && n > 0));
        check(base_out == fin, req, "final base", 64'(base_out), 64'(fin));
        if (!stall_en)
            check(cyc == n + 2, "R10", "busy length", 64'(cyc), 64'(n + 2));
        start = poke;
        @(negedge clk);
        start = 1'b0;
        check(!busy && !done, "R11", "idle after done", 64'({busy, done}), 64'd0);
        exp_q.delete();
    endtask

    initial begin
        #(5.0 * 150000);
        check(1'b0, "R10", "watchdog", 64'd1, 64'd0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check({busy, mem_req, done, base_wb} == 4'b0, "R1", "reset outputs",
              64'({busy, mem_req, done, base_wb}), 64'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check({busy, mem_req, done, base_wb} == 4'b0, "R1", "idle outputs",
              64'({busy, mem_req, done, base_wb}), 64'd0);

        run_cmd(16'h000E, 32'h00080010, 1'b1, 2'd0, 1'b1, 1'b0, "R2"); // 0x80010..18, wb 0x8001C
        run_cmd(16'h000E, 32'h00080010, 1'b1, 2'd1, 1'b1, 1'b0, "R3");
        run_cmd(16'h8421, 32'h00009000, 1'b0, 2'd2, 1'b1, 1'b0, "R4");
        run_cmd(16'hF00F, 32'h00001000, 1'b0, 2'd3, 1'b1, 1'b0, "R5");
        run_cmd(16'hFFFF, 32'h00000040, 1'b1, 2'd3, 1'b0, 1'b0, "R8");
        run_cmd(16'h8000, 32'hFFFFFFFC, 1'b0, 2'd1, 1'b1, 1'b0, "R3");
        run_cmd(16'h0000, 32'h12345678, 1'b1, 2'd0, 1'b1, 1'b0, "R9");
        run_cmd(16'h0000, 32'h00000100, 1'b0, 2'd3, 1'b1, 1'b0, "R9");
        run_cmd(16'h0A50, 32'h00002000, 1'b1, 2'd0, 1'b1, 1'b1, "R11");
        stall_en = 1'b1;
        run_cmd(16'h3C3C, 32'h00004000, 1'b0, 2'd0, 1'b1, 1'b0, "R7");
        run_cmd(16'hA5A5, 32'h00008000, 1'b1, 2'd2, 1'b0, 1'b1, "R4");
        stall_en = 1'b0;
        repeat (3) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule